// File: doc/BRIEF.md
# Page-Granular Secure Memory Zone Filter

This block sits in front of on-chip memories such as a boot ROM and a system RAM and decides, for every transaction, whether it may proceed. Each guarded zone is divided by a single boundary into a lower secure part and an upper non-secure part. The boundary is a page count of 4 KiB pages supplied by a configuration bank outside this block. The lower part always starts at the zone base, and the upper part always runs to the zone top.

A requester presents an address, a byte length, its security state and its direction. One cycle later the filter returns a verdict. Secure requesters may reach any byte of a zone. Non-secure requesters may reach only the upper part. Any access that leaves its zone, or that touches the secure part for a non-secure requester, is refused as a whole. Each refusal raises a one-cycle violation pulse and records the offending address and direction.

Top module: `mzone_filter`

## Requirements
- R1: A response (`rsp_vld` high for one cycle) appears exactly one clock after each cycle with `req_vld` high. `rsp_vld` stays low in every cycle that does not follow a request.
- R2: An access is granted only if its first byte and its last byte both lie in the same zone, with `base <= addr` and `last < base + zone_pages*4096`. Zone 0 has base 0x0000_0000 and 32 pages. Zone 1 has base 0x1000_0000 and 64 pages. Any other access is denied for every requester.
- R3: The secure limit of zone z is `base + min(count, zone_pages)*4096`. Here `count` is the 10-bit field `bnd_pages[z*10 +: 10]`.
- R4: A secure requester (`req_sec`=1) is granted any access that lies wholly inside a zone, whichever part or parts it touches.
- R5: A non-secure requester is granted only when the start address is at or above the secure limit. An access that straddles the limit is denied as a whole.
- R6: A count larger than the zone's page count is clamped, which makes the whole zone secure. A count of zero makes the whole zone non-secure.
- R7: A length of zero is treated as a one-byte access.
- R8: On a denied response, `viol_pulse` is high in that same cycle. At the same time, `fault_addr` and `fault_wr` take the refused request's address and direction, and they hold until the next denial.
- R9: While reset is asserted, `rsp_vld`, `rsp_grant`, `viol_pulse`, `fault_addr` and `fault_wr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_pages | input | 20 | Per-zone boundary page counts, 10 bits per zone |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | 32 | First byte address |
| req_len | input | 16 | Length in bytes (0 means 1) |
| req_sec | input | 1 | Requester is secure |
| req_wr | input | 1 | Request is a write |
| rsp_vld | output | 1 | Verdict valid |
| rsp_grant | output | 1 | 1 grant, 0 deny |
| viol_pulse | output | 1 | One-cycle pulse on a denial |
| fault_addr | output | 32 | Address of the most recent denied request |
| fault_wr | output | 1 | Direction of the most recent denied request |

## Verification
The assertions assume that the zone table places zones that do not overlap, that the zones stay below the top of the address space, and that request inputs are known whenever `req_vld` is high. The bench keeps the default zone table. It draws addresses within a few pages of each zone base, each secure limit and each zone top, so that every straddle and edge case falls inside the modelled range. Lengths stay inside the length port's width, and boundary counts are drawn both below and above each zone's size, so that clamping is exercised without leaving the assumed input space.

// File: rtl/mzone_pkg.sv
`timescale 1ns/1ps
// Shared constants for the memory zone filter.
// Assumes byte addressing and a fixed 4 KiB page.
package mzone_pkg;
    localparam int PAGE_SHIFT = 12;
endpackage

// File: rtl/mzone_bound.sv
`timescale 1ns/1ps
// Computes the secure limit and the top of one zone from its boundary count.
// Assumes the zone fits below 2**ADDR_W; the result is one bit wider.
module mzone_bound
    import mzone_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W = 10,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter int PAGES = 32
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [ADDR_W:0]  lim,
    output logic [ADDR_W:0]  top
);
    localparam int EW = CNT_W + 1;
    localparam logic [EW-1:0] PAGES_V = EW'(PAGES);
    localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE};
    localparam logic [ADDR_W:0] TOP_X = BASE_X + ((ADDR_W+1)'(PAGES) << PAGE_SHIFT);

    logic [EW-1:0] eff;

    // Clamp the count to the zone size and scale pages to bytes.
    always_comb begin
        eff = ({1'b0, cnt} > PAGES_V) ? PAGES_V : {1'b0, cnt};
        lim = BASE_X + ((ADDR_W+1)'(eff) << PAGE_SHIFT);
        top = TOP_X;
    end
endmodule

// File: rtl/mzone_judge.sv
`timescale 1ns/1ps
// Decides whether one access is allowed by one zone.
// Assumes first/last are byte addresses with last >= first.
module mzone_judge #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [ADDR_W:0] first,
    input  logic [ADDR_W:0] last,
    input  logic            sec,
    input  logic [ADDR_W:0] lim,
    input  logic [ADDR_W:0] top,
    output logic            hit,
    output logic            grant
);
    localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE};

    // Start in zone; whole access in zone; non-secure must clear the limit.
    always_comb begin
        hit   = (first >= BASE_X) && (first < top);
        grant = hit && (last < top) && (sec || (first >= lim));
    end
endmodule

// File: rtl/mzone_filter.sv
`timescale 1ns/1ps
// Top of the secure memory zone filter: one verdict per request, one cycle late.
// Assumes zones do not overlap and sit below the top of the address space.
module mzone_filter #(
    parameter int ADDR_W = 32,
    parameter int LEN_W = 16,
    parameter int CNT_W = 10,
    parameter int NUM_ZONES = 2,
    parameter logic [NUM_ZONES*ADDR_W-1:0] ZONE_BASE = {32'h1000_0000, 32'h0000_0000},
    parameter logic [NUM_ZONES*16-1:0]     ZONE_PAGES = {16'd64, 16'd32}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_ZONES*CNT_W-1:0] bnd_pages,
    input  logic                       req_vld,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LEN_W-1:0]           req_len,
    input  logic                       req_sec,
    input  logic                       req_wr,
    output logic                       rsp_vld,
    output logic                       rsp_grant,
    output logic                       viol_pulse,
    output logic [ADDR_W-1:0]          fault_addr,
    output logic                       fault_wr
);
    localparam int XW = ADDR_W + 1;

    logic [XW-1:0]          first, last;
    logic [LEN_W-1:0]       len_m1;
    logic [NUM_ZONES-1:0]   z_grant, z_hit;
    logic [XW-1:0]          z_lim [NUM_ZONES];
    logic [XW-1:0]          z_top [NUM_ZONES];
    logic                   verdict;

    // Form the inclusive byte range; a zero length counts as one byte.
    always_comb begin
        len_m1 = (req_len == '0) ? '0 : req_len - 1'b1;
        first  = {1'b0, req_addr};
        last   = first + XW'(len_m1);
    end

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        mzone_bound #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W),
            .BASE(ZONE_BASE[z*ADDR_W +: ADDR_W]),
            .PAGES(int'(ZONE_PAGES[z*16 +: 16]))
        ) u_bound (
            .cnt(bnd_pages[z*CNT_W +: CNT_W]),
            .lim(z_lim[z]),
            .top(z_top[z])
        );

        mzone_judge #(
            .ADDR_W(ADDR_W),
            .BASE(ZONE_BASE[z*ADDR_W +: ADDR_W])
        ) u_judge (
            .first(first), .last(last), .sec(req_sec),
            .lim(z_lim[z]), .top(z_top[z]),
            .hit(z_hit[z]), .grant(z_grant[z])
        );

        // R3: the clamped limit never leaves its zone.
        a_r3_lim_in_zone: assert property (@(posedge clk) disable iff (!rst_n)
            (z_lim[z] <= z_top[z]) && (z_lim[z] >= {1'b0, ZONE_BASE[z*ADDR_W +: ADDR_W]}));
        // R2: a zone can only grant an access that starts inside it.
        a_r2_grant_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
            z_grant[z] |-> z_hit[z]);
    end

    // Zones do not overlap, so at most one can grant.
    always_comb verdict = |z_grant;

    // Register the verdict and the violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld    <= 1'b0;
            rsp_grant  <= 1'b0;
            viol_pulse <= 1'b0;
        end else begin
            rsp_vld    <= req_vld;
            rsp_grant  <= req_vld && verdict;
            viol_pulse <= req_vld && !verdict;
        end
    end

    // Capture address and direction of each refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
            fault_wr   <= 1'b0;
        end else if (req_vld && !verdict) begin
            fault_addr <= req_addr;
            fault_wr   <= req_wr;
        end
    end

    // R1: a response follows every request and nothing else.
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);
    // R8: a pulse only accompanies a denied response.
    a_r8_pulse_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> (rsp_vld && !rsp_grant));
    // R8: the fault record moves only with a pulse.
    a_r8_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_pulse |-> ($stable(fault_addr) && $stable(fault_wr)));
    a_r8_fault_value: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> (fault_addr == $past(req_addr)));
endmodule

// File: tb/sim_mzone_filter.sv
`timescale 1ns/1ps
module sim_mzone_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bnd_pages = '0;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_sec = 1'b0;
    logic        req_wr = 1'b0;
    logic        rsp_vld, rsp_grant, viol_pulse, fault_wr;
    logic [31:0] fault_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_faddr = '0;
    logic        m_fwr = 1'b0;

    always #2.5 clk = ~clk;

    mzone_filter u0 (
        .clk(clk), .rst_n(rst_n), .bnd_pages(bnd_pages),
        .req_vld(req_vld), .req_addr(req_addr), .req_len(req_len),
        .req_sec(req_sec), .req_wr(req_wr),
        .rsp_vld(rsp_vld), .rsp_grant(rsp_grant), .viol_pulse(viol_pulse),
        .fault_addr(fault_addr), .fault_wr(fault_wr)
    );

    function automatic longint zbase(int z);
        return (z == 0) ? 64'h0 : 64'h1000_0000;
    endfunction
    function automatic longint zpages(int z);
        return (z == 0) ? 64'd32 : 64'd64;
    endfunction
    function automatic longint zlim(int z, logic [19:0] b);
        longint c = longint'(b[z*10 +: 10]);
        if (c > zpages(z)) c = zpages(z);
        return zbase(z) + c * 4096;
    endfunction

    function automatic bit ref_grant(longint a, longint n, bit s, logic [19:0] b);
        longint last = a + ((n == 0) ? 0 : n - 1);
        for (int z = 0; z < 2; z++) begin
            longint top = zbase(z) + zpages(z) * 4096;
            if (a >= zbase(z) && a < top)
                return (last < top) && (s || a >= zlim(z, b));
        end
        return 1'b0;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic access(string tag, logic [31:0] a, logic [15:0] n, bit s, bit w);
        bit e;
        @(negedge clk);
        req_vld = 1'b1; req_addr = a; req_len = n; req_sec = s; req_wr = w;
        e = ref_grant(longint'(a), longint'(n), s, bnd_pages);
        @(negedge clk);
        req_vld = 1'b0;
        if (!e) begin m_faddr = a; m_fwr = w; end
        check({tag, " rsp_vld"}, rsp_vld, 1);
        check({tag, " grant"}, rsp_grant, e);
        check({tag, " pulse"}, viol_pulse, !e);
        check({tag, " fault_addr"}, fault_addr, m_faddr);
        check({tag, " fault_wr"}, fault_wr, m_fwr);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 rsp_vld", rsp_vld, 0);
        check("R9 grant", rsp_grant, 0);
        check("R9 pulse", viol_pulse, 0);
        check("R9 fault_addr", fault_addr, 0);
        check("R9 fault_wr", fault_wr, 0);
        rst_n = 1'b1;
        bnd_pages = {10'd16, 10'd8};   // zone0 limit 0x8000, zone1 limit 0x1001_0000
        @(negedge clk);
        check("R1 idle rsp_vld", rsp_vld, 0);

        access("R4 sec in secure part", 32'h0000_1000, 16'd64, 1, 0);
        check("R4 grant fixed", rsp_grant, 1);
        access("R5 ns in secure part", 32'h0000_2000, 16'd4, 0, 1);
        check("R8 fault addr fixed", fault_addr, 32'h0000_2000);
        access("R5 ns straddle", 32'h0000_7FF0, 16'd32, 0, 0);
        check("R5 straddle denied", rsp_grant, 0);
        access("R5 ns at limit", 32'h0000_8000, 16'd16, 0, 0);
        check("R5 at limit granted", rsp_grant, 1);
        check("R8 fault held", fault_addr, 32'h0000_7FF0);
        access("R4 sec straddle", 32'h0000_7FF0, 16'd32, 1, 0);
        access("R2 ns ends at top", 32'h0001_FFF0, 16'd16, 0, 0);
        check("R2 last byte at top", rsp_grant, 1);
        access("R2 crosses top", 32'h0001_FFF0, 16'd17, 1, 0);
        check("R2 crossing denied", rsp_grant, 0);
        access("R2 outside zones", 32'h2000_0000, 16'd4, 1, 1);
        access("R7 zero length", 32'h0001_FFFF, 16'd0, 0, 0);
        check("R7 zero len granted", rsp_grant, 1);
        access("R3 zone1 ns below", 32'h1000_FFFC, 16'd4, 0, 0);
        access("R3 zone1 ns at limit", 32'h1001_0000, 16'd4, 0, 0);

        bnd_pages = {10'd1023, 10'd0};
        access("R6 zero count", 32'h0000_0000, 16'd8, 0, 0);
        check("R6 all ns granted", rsp_grant, 1);
        access("R6 clamp", 32'h1003_FFF0, 16'd4, 0, 1);
        check("R6 clamped denied", rsp_grant, 0);

        for (int i = 0; i < 400; i++) begin
            int z = $urandom_range(0, 1);
            int pick = $urandom_range(0, 2);
            longint anchor;
            longint a;
            bnd_pages = {10'($urandom_range(0, 80)), 10'($urandom_range(0, 40))};
            anchor = (pick == 0) ? zbase(z) : (pick == 1) ? zlim(z, bnd_pages)
                                            : zbase(z) + zpages(z) * 4096;
            a = anchor + longint'($urandom_range(0, 8192)) - 4096;
            if (a < 0) a = 0;
            access("R2,R4,R5 random", 32'(a), 16'($urandom_range(0, 6000)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule